// File: doc/BRIEF.md
# Keyed Command Sequence Decoder for a Word-Wide Flash Model

This block sits on the write side of a word-wide flash device model and turns bus write cycles into operation requests. Every write brings an address and a data word. Only the low fifteen address bits and the low command byte take part in matching. The decoder waits for a fixed two-write unlock key. It then reads the command byte that follows. Program, three kinds of erase, identification entry, query entry and return-to-read are all reached this way. An erase must repeat the unlock key before its final cycle. Any write that breaks a sequence sends the decoder straight back to read mode.

A completed program or erase shows up as a one-clock start strobe. The strobe comes with an operation code, the full target address and the full data word. These values stay on the outputs until the next strobe. A two-bit mode output tells the read path whether the array, the identification words or the query table should answer. While the device is in identification mode, a small read port returns the maker and device codes.

The array itself, operation timing and the query table contents belong to other blocks. The environment reports an operation in progress on the `busy` input. While `busy` is high, the decoder ignores every write.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode` is 0 (read), `op_start` and `id_valid` are 0, and `op_kind`, `op_addr` and `op_data` are 0.
- R2: The unlock key is byte AAh written at command address 5555h, then byte 55h at 2AAAh. Address bits 18..15 and data bits 15..8 are ignored when any command cycle is matched.
- R3: Key, then A0h at 5555h, then one more write: `op_start` pulses with `op_kind` 0 (program). `op_addr` is the whole address of that last write and `op_data` is its whole data word. The pulse appears in the clock after that write.
- R4: Key, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 10h at 5555h: `op_start` pulses with `op_kind` 3 (chip erase).
- R5: The same five-write prefix followed by 30h at any address: `op_start` pulses with `op_kind` 1 (sector erase). `op_sector` equals address bits 18..11 of that write.
- R6: The same prefix followed by 50h at any address: `op_start` pulses with `op_kind` 2 (block erase). `op_block` equals address bits 18..15 of that write.
- R7: Key then 90h at 5555h sets `mode` to 1 (identification). Key then 98h at 5555h sets `mode` to 2 (query). `mode` never takes the value 3.
- R8: A lone F0h write at any address while idle sets `mode` to 0. So does the key followed by F0h at 5555h.
- R9: A write that does not match the next expected cycle ends the sequence and sets `mode` to 0. That write starts nothing. The next sequence must begin again with the key.
- R10: While `busy` is 1, writes change nothing: no strobe, no mode change, and a partly entered sequence keeps its position.
- R11: In mode 1, `rd_addr` 0 gives `id_data` 00BFh and `rd_addr` 1 gives 2781h, with `id_valid` 1. At any other address or in any other mode, `id_valid` and `id_data` are 0.
- R12: An idle write that is neither AAh at 5555h nor F0h leaves `mode` as it was.
- R13: `op_start` is high for exactly one clock. `op_kind`, `op_addr` and `op_data` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle in this clock |
| wr_addr | input | 19 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Internal program or erase in progress |
| rd_addr | input | 19 | Read address for the identification port |
| mode | output | 2 | 0 read, 1 identification, 2 query |
| op_start | output | 1 | One-clock operation start strobe |
| op_kind | output | 2 | 0 program, 1 sector, 2 block, 3 chip erase |
| op_addr | output | 19 | Target address of the last started operation |
| op_data | output | 16 | Program data of the last started operation |
| op_sector | output | 8 | Sector index taken from op_addr |
| op_block | output | 4 | Block index taken from op_addr |
| id_valid | output | 1 | Identification word is being returned |
| id_data | output | 16 | Maker or device code |

## Verification
Two situations are hard to reach from the ports. One is a sequence that fails at its fifth or sixth write. The other is `busy` arriving while a sequence is only partly entered. Random writes almost never get that deep into an erase. The stimulus therefore builds complete, correctly keyed sequences with random upper address bits and random high data bytes. In a share of them, one randomly chosen cycle is replaced with random garbage, and `busy` is raised on random individual writes. This drives aborts and frozen progress at every depth of every command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int CMD_BYTE_W = 8;

   typedef enum logic [1:0] {
      MODE_READ  = 2'd0,
      MODE_ID    = 2'd1,
      MODE_QUERY = 2'd2
   } mode_e;

   typedef enum logic [1:0] {
      OP_PROG   = 2'd0,
      OP_SECTOR = 2'd1,
      OP_BLOCK  = 2'd2,
      OP_CHIP   = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_KEY1,
      SQ_KEY2,
      SQ_PROG,
      SQ_ERA1,
      SQ_ERA2,
      SQ_ERA3
   } seq_e;

   // command byte values, index order used by the comparator bank
   localparam int NUM_CODES = 10;
   localparam logic [CMD_BYTE_W-1:0] CODE_TABLE [NUM_CODES] = '{
      8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'h98, 8'hF0, 8'h10, 8'h30, 8'h50
   };
   localparam int IX_UA = 0, IX_UB = 1, IX_PROG = 2, IX_ERASE = 3, IX_ID = 4,
                  IX_QUERY = 5, IX_EXIT = 6, IX_CHIP = 7, IX_SECTOR = 8, IX_BLOCK = 9;

   typedef struct packed {
      logic at_a;
      logic at_b;
      logic c_ua;
      logic c_ub;
      logic c_prog;
      logic c_erase;
      logic c_id;
      logic c_query;
      logic c_exit;
      logic c_chip;
      logic c_sector;
      logic c_block;
   } hit_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
   import flash_cmd_pkg::*;
#(
   parameter int CMD_AW = 15,
   parameter logic [CMD_AW-1:0] KEY_A_ADDR = 15'h5555,
   parameter logic [CMD_AW-1:0] KEY_B_ADDR = 15'h2AAA
) (
   input  logic [CMD_AW-1:0]     cmd_addr,
   input  logic [CMD_BYTE_W-1:0] cmd_byte,
   output hit_t                  hit
);

   logic [NUM_CODES-1:0] eq;

   for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
      assign eq[i] = (cmd_byte == CODE_TABLE[i]);
   end

   always_comb begin
      hit.at_a     = (cmd_addr == KEY_A_ADDR);
      hit.at_b     = (cmd_addr == KEY_B_ADDR);
      hit.c_ua     = eq[IX_UA];
      hit.c_ub     = eq[IX_UB];
      hit.c_prog   = eq[IX_PROG];
      hit.c_erase  = eq[IX_ERASE];
      hit.c_id     = eq[IX_ID];
      hit.c_query  = eq[IX_QUERY];
      hit.c_exit   = eq[IX_EXIT];
      hit.c_chip   = eq[IX_CHIP];
      hit.c_sector = eq[IX_SECTOR];
      hit.c_block  = eq[IX_BLOCK];
   end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  logic  busy,
   input  hit_t  hit,
   output mode_e mode_q,
   output logic  fire,
   output op_e   fire_kind,
   output logic  prog_armed
);

   seq_e  state_q, state_d;
   mode_e mode_d;
   logic  abort;
   logic  take;

   assign take       = wr_en && !busy;
   assign prog_armed = (state_q == SQ_PROG);

   always_comb begin
      state_d   = state_q;
      mode_d    = mode_q;
      fire      = 1'b0;
      fire_kind = OP_PROG;
      abort     = 1'b0;
      if (take) begin
         unique case (state_q)
            SQ_IDLE: begin
               if (hit.at_a && hit.c_ua) state_d = SQ_KEY1;
               else if (hit.c_exit)      mode_d  = MODE_READ;
            end
            SQ_KEY1: begin
               if (hit.at_b && hit.c_ub) state_d = SQ_KEY2;
               else                      abort   = 1'b1;
            end
            SQ_KEY2: begin
               if (!hit.at_a)          abort   = 1'b1;
               else if (hit.c_prog)    state_d = SQ_PROG;
               else if (hit.c_erase)   state_d = SQ_ERA1;
               else if (hit.c_id) begin
                  state_d = SQ_IDLE;
                  mode_d  = MODE_ID;
               end else if (hit.c_query) begin
                  state_d = SQ_IDLE;
                  mode_d  = MODE_QUERY;
               end else if (hit.c_exit) begin
                  state_d = SQ_IDLE;
                  mode_d  = MODE_READ;
               end else abort = 1'b1;
            end
            SQ_PROG: begin
               fire      = 1'b1;
               fire_kind = OP_PROG;
               state_d   = SQ_IDLE;
            end
            SQ_ERA1: begin
               if (hit.at_a && hit.c_ua) state_d = SQ_ERA2;
               else                      abort   = 1'b1;
            end
            SQ_ERA2: begin
               if (hit.at_b && hit.c_ub) state_d = SQ_ERA3;
               else                      abort   = 1'b1;
            end
            SQ_ERA3: begin
               if (hit.at_a && hit.c_chip) begin
                  fire      = 1'b1;
                  fire_kind = OP_CHIP;
                  state_d   = SQ_IDLE;
               end else if (hit.c_sector) begin
                  fire      = 1'b1;
                  fire_kind = OP_SECTOR;
                  state_d   = SQ_IDLE;
               end else if (hit.c_block) begin
                  fire      = 1'b1;
                  fire_kind = OP_BLOCK;
                  state_d   = SQ_IDLE;
               end else abort = 1'b1;
            end
            default: abort = 1'b1;
         endcase
         if (abort) begin
            state_d = SQ_IDLE;
            mode_d  = MODE_READ;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mode_q  <= MODE_READ;
      end else begin
         state_q <= state_d;
         mode_q  <= mode_d;
      end
   end

endmodule

// File: rtl/flash_op_latch.sv
module flash_op_latch
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  op_e               fire_kind,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              start_q,
   output op_e               kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         kind_q  <= OP_PROG;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         start_q <= fire;
         if (fire) begin
            kind_q <= fire_kind;
            addr_q <= addr_in;
            data_q <= data_in;
         end
      end
   end

endmodule

// File: rtl/flash_id_port.sv
module flash_id_port
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] MAKER_CODE = 16'h00BF,
   parameter logic [DATA_W-1:0] PART_CODE  = 16'h2781,
   parameter bit  REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mode_e             mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              id_valid,
   output logic [DATA_W-1:0] id_data
);

   logic              hit;
   logic [DATA_W-1:0] word;

   assign hit  = (mode == MODE_ID) && (rd_addr[ADDR_W-1:1] == '0);
   assign word = hit ? (rd_addr[0] ? PART_CODE : MAKER_CODE) : '0;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            id_valid <= 1'b0;
            id_data  <= '0;
         end else begin
            id_valid <= hit;
            id_data  <= word;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign id_valid   = hit;
      assign id_data    = word;
   end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 16,
   parameter int CMD_AW   = 15,
   parameter int SECT_LSB = 11,
   parameter int BLK_LSB  = 15,
   parameter logic [CMD_AW-1:0] KEY_A_ADDR = 15'h5555,
   parameter logic [CMD_AW-1:0] KEY_B_ADDR = 15'h2AAA,
   parameter logic [DATA_W-1:0] MAKER_CODE = 16'h00BF,
   parameter logic [DATA_W-1:0] PART_CODE  = 16'h2781,
   parameter bit  ID_REG_OUT = 1'b0,
   localparam int SECT_W = ADDR_W - SECT_LSB,
   localparam int BLK_W  = ADDR_W - BLK_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [1:0]        mode,
   output logic              op_start,
   output logic [1:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic [SECT_W-1:0] op_sector,
   output logic [BLK_W-1:0]  op_block,
   output logic              id_valid,
   output logic [DATA_W-1:0] id_data
);

   if (CMD_AW > ADDR_W) begin : g_bad_aw
      $error("CMD_AW must not exceed ADDR_W");
   end
   if (DATA_W < CMD_BYTE_W) begin : g_bad_dw
      $error("DATA_W must hold a command byte");
   end
   if (SECT_LSB >= ADDR_W || BLK_LSB >= ADDR_W || SECT_LSB > BLK_LSB) begin : g_bad_idx
      $error("sector and block index positions are inconsistent");
   end

   hit_t  hit;
   mode_e mode_q;
   logic  fire;
   op_e   fire_kind;
   op_e   kind_q;
   logic  prog_armed;

   flash_cmd_match #(
      .CMD_AW     (CMD_AW),
      .KEY_A_ADDR (KEY_A_ADDR),
      .KEY_B_ADDR (KEY_B_ADDR)
   ) u_match (
      .cmd_addr (wr_addr[CMD_AW-1:0]),
      .cmd_byte (wr_data[CMD_BYTE_W-1:0]),
      .hit      (hit)
   );

   flash_cmd_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .busy       (busy),
      .hit        (hit),
      .mode_q     (mode_q),
      .fire       (fire),
      .fire_kind  (fire_kind),
      .prog_armed (prog_armed)
   );

   flash_op_latch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .fire_kind (fire_kind),
      .addr_in   (wr_addr),
      .data_in   (wr_data),
      .start_q   (op_start),
      .kind_q    (kind_q),
      .addr_q    (op_addr),
      .data_q    (op_data)
   );

   flash_id_port #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .MAKER_CODE (MAKER_CODE),
      .PART_CODE  (PART_CODE),
      .REG_OUT    (ID_REG_OUT)
   ) u_id (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .rd_addr  (rd_addr),
      .id_valid (id_valid),
      .id_data  (id_data)
   );

   assign mode      = mode_q;
   assign op_kind   = kind_q;
   assign op_sector = op_addr[ADDR_W-1:SECT_LSB];
   assign op_block  = op_addr[ADDR_W-1:BLK_LSB];

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16,
   parameter int CMD_AW = 15,
   parameter logic [CMD_AW-1:0] KEY_A_ADDR = 15'h5555,
   parameter logic [DATA_W-1:0] MAKER_CODE = 16'h00BF,
   parameter bit  ID_REG_OUT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              busy,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [1:0]        mode,
   input logic              op_start,
   input logic [1:0]        op_kind,
   input logic [ADDR_W-1:0] op_addr,
   input logic [DATA_W-1:0] op_data,
   input logic              id_valid,
   input logic [DATA_W-1:0] id_data,
   input logic              prog_armed
);

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> !op_start); // R13

   AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_start |-> ($stable(op_addr) && $stable(op_data) && $stable(op_kind))); // R13

   AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> !op_start); // R10

   AST_BUSY_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode)); // R10

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3); // R7

   AST_CHIP_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && op_kind == 2'd3) |->
         ($past(wr_addr[CMD_AW-1:0]) == KEY_A_ADDR && $past(wr_data[7:0]) == 8'h10)); // R4

   AST_PROG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_armed && wr_en && !busy) |=>
         (op_start && op_kind == 2'd0 && op_addr == $past(wr_addr) && op_data == $past(wr_data))); // R3

   AST_EXIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && !prog_armed && wr_data[7:0] == 8'hF0) |=> mode == 2'd0); // R8

   if (!ID_REG_OUT) begin : g_id_chk
      AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'd1 && rd_addr == '0) |-> (id_valid && id_data == MAKER_CODE)); // R11
      AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (mode != 2'd1) |-> (!id_valid && id_data == '0)); // R11
   end

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .CMD_AW     (CMD_AW),
   .KEY_A_ADDR (KEY_A_ADDR),
   .MAKER_CODE (MAKER_CODE),
   .ID_REG_OUT (ID_REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .busy       (busy),
   .rd_addr    (rd_addr),
   .mode       (mode),
   .op_start   (op_start),
   .op_kind    (op_kind),
   .op_addr    (op_addr),
   .op_data    (op_data),
   .id_valid   (id_valid),
   .id_data    (id_data),
   .prog_armed (prog_armed)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [18:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        busy = 1'b0;
   logic [18:0] rd_addr = '0;
   logic [1:0]  mode;
   logic        op_start;
   logic [1:0]  op_kind;
   logic [18:0] op_addr;
   logic [15:0] op_data;
   logic [7:0]  op_sector;
   logic [3:0]  op_block;
   logic        id_valid;
   logic [15:0] id_data;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   flash_cmd_seq u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .busy (busy), .rd_addr (rd_addr), .mode (mode),
      .op_start (op_start), .op_kind (op_kind), .op_addr (op_addr),
      .op_data (op_data), .op_sector (op_sector), .op_block (op_block),
      .id_valid (id_valid), .id_data (id_data)
   );

   // expected-value model built from the requirements
   int          ms = 0;
   logic [1:0]  mm = 2'd0;
   logic        es = 1'b0;
   logic [1:0]  ek = 2'd0;
   logic [18:0] ea = '0;
   logic [15:0] ed = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_step(input logic [18:0] a, input logic [15:0] d, input bit bsy);
      bit ka, kb, ab;
      logic [7:0] c;
      ka = (a[14:0] == 15'h5555);
      kb = (a[14:0] == 15'h2AAA);
      c  = d[7:0];
      ab = 1'b0;
      es = 1'b0;
      if (!bsy) begin
         case (ms)
            0: if (ka && c == 8'hAA) ms = 1; else if (c == 8'hF0) mm = 2'd0;
            1: if (kb && c == 8'h55) ms = 2; else ab = 1'b1;
            2: begin
               if (!ka) ab = 1'b1;
               else if (c == 8'hA0) ms = 3;
               else if (c == 8'h80) ms = 4;
               else if (c == 8'h90) begin ms = 0; mm = 2'd1; end
               else if (c == 8'h98) begin ms = 0; mm = 2'd2; end
               else if (c == 8'hF0) begin ms = 0; mm = 2'd0; end
               else ab = 1'b1;
            end
            3: begin es = 1'b1; ek = 2'd0; ea = a; ed = d; ms = 0; end
            4: if (ka && c == 8'hAA) ms = 5; else ab = 1'b1;
            5: if (kb && c == 8'h55) ms = 6; else ab = 1'b1;
            default: begin
               if (ka && c == 8'h10)  begin es = 1'b1; ek = 2'd3; end
               else if (c == 8'h30)   begin es = 1'b1; ek = 2'd1; end
               else if (c == 8'h50)   begin es = 1'b1; ek = 2'd2; end
               else ab = 1'b1;
               if (es) begin ea = a; ed = d; ms = 0; end
            end
         endcase
         if (ab) begin ms = 0; mm = 2'd0; end
      end
   endtask

   // one bus write; called at a falling edge, returns one clock later
   task automatic wr(input string req, input logic [18:0] a, input logic [15:0] d, input bit bsy);
      wr_en = 1'b1; wr_addr = a; wr_data = d; busy = bsy;
      @(negedge clk);
      wr_en = 1'b0; busy = 1'b0;
      model_step(a, d, bsy);
      chk(req, mode, mm);
      chk(req, op_start, es);
      chk(req, op_kind, ek);
      chk(req, op_addr, ea);
      chk(req, op_data, ed);
   endtask

   function automatic logic [18:0] at(input logic [14:0] lo);
      logic [3:0] hi;
      hi = 4'($urandom);
      return {hi, lo};
   endfunction

   function automatic logic [15:0] cb(input logic [7:0] b);
      logic [7:0] hi;
      hi = 8'($urandom);
      return {hi, b};
   endfunction

   task automatic key(input string req);
      wr(req, at(15'h5555), cb(8'hAA), 1'b0);
      wr(req, at(15'h2AAA), cb(8'h55), 1'b0);
   endtask

   task automatic erase_prefix(input string req);
      key(req);
      wr(req, at(15'h5555), cb(8'h80), 1'b0);
      wr(req, at(15'h5555), cb(8'hAA), 1'b0);
      wr(req, at(15'h2AAA), cb(8'h55), 1'b0);
   endtask

   task automatic rand_seq;
      logic [18:0] sa [6];
      logic [15:0] sd [6];
      int n, kind, bad;
      string tag;
      kind = int'($urandom % 10);
      sa[0] = at(15'h5555); sd[0] = cb(8'hAA);
      sa[1] = at(15'h2AAA); sd[1] = cb(8'h55);
      sa[2] = at(15'h5555);
      n = 3;
      case (kind)
         0: begin sd[2] = cb(8'hA0); sa[3] = 19'($urandom); sd[3] = 16'($urandom); n = 4; tag = "R3"; end
         1, 2, 3: begin
            sd[2] = cb(8'h80);
            sa[3] = at(15'h5555); sd[3] = cb(8'hAA);
            sa[4] = at(15'h2AAA); sd[4] = cb(8'h55);
            n = 6;
            if (kind == 1) begin sa[5] = 19'($urandom); sd[5] = cb(8'h30); tag = "R5"; end
            else if (kind == 2) begin sa[5] = 19'($urandom); sd[5] = cb(8'h50); tag = "R6"; end
            else begin sa[5] = at(15'h5555); sd[5] = cb(8'h10); tag = "R4"; end
         end
         4: begin sd[2] = cb(8'h90); tag = "R7"; end
         5: begin sd[2] = cb(8'h98); tag = "R7"; end
         6: begin sa[0] = 19'($urandom); sd[0] = cb(8'hF0); n = 1; tag = "R8"; end
         7: begin sd[2] = cb(8'hF0); tag = "R8"; end
         8: begin sa[0] = 19'($urandom); sd[0] = 16'($urandom); n = 1; tag = "R12"; end
         default: begin sd[2] = cb(8'h90); tag = "R7"; end
      endcase
      if (($urandom % 4) == 0 && n > 1) begin
         bad = int'($urandom % n);
         sa[bad] = 19'($urandom);
         sd[bad] = 16'($urandom);
         tag = "R9";
      end
      for (int i = 0; i < n; i++) begin
         bit b;
         b = (($urandom % 10) == 0);
         wr(b ? "R10" : tag, sa[i], sd[i], b);
      end
   endtask

   initial begin
      logic [18:0] hold_a;
      void'($urandom(32'd20241));
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1", mode, 2'd0);
      chk("R1", op_start, 1'b0);
      chk("R1", id_valid, 1'b0);
      chk("R1", op_addr, 19'd0);
      chk("R1", op_data, 16'd0);
      chk("R1", op_kind, 2'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 + R3: program with noise in ignored bits
      wr("R2", 19'h7D555, 16'h3CAA, 1'b0);
      wr("R2", 19'h2AAAA, 16'hE155, 1'b0);
      wr("R3", 19'h55555, 16'h00A0, 1'b0);
      wr("R3", 19'h41234, 16'hBEEF, 1'b0);
      chk("R3", op_start, 1'b1);
      chk("R3", op_kind, 2'd0);
      chk("R3", op_addr, 19'h41234);
      chk("R3", op_data, 16'hBEEF);
      // R13: one-clock strobe and held payload
      @(negedge clk);
      chk("R13", op_start, 1'b0);
      chk("R13", op_addr, 19'h41234);
      chk("R13", op_data, 16'hBEEF);

      // R5: sector erase
      erase_prefix("R5");
      wr("R5", 19'h5A800, 16'h0030, 1'b0);
      chk("R5", op_kind, 2'd1);
      chk("R5", op_sector, 8'hB5);
      // R6: block erase
      erase_prefix("R6");
      wr("R6", 19'h6F123, 16'h0050, 1'b0);
      chk("R6", op_kind, 2'd2);
      chk("R6", op_block, 4'hD);
      // R4: chip erase
      erase_prefix("R4");
      wr("R4", 19'h05555, 16'h0010, 1'b0);
      chk("R4", op_start, 1'b1);
      chk("R4", op_kind, 2'd3);

      // R7 + R11: identification mode and codes
      key("R7");
      wr("R7", 19'h05555, 16'h0090, 1'b0);
      chk("R7", mode, 2'd1);
      rd_addr = 19'd0; #1;
      chk("R11", id_data, 16'h00BF);
      chk("R11", id_valid, 1'b1);
      rd_addr = 19'd1; #1;
      chk("R11", id_data, 16'h2781);
      rd_addr = 19'd2; #1;
      chk("R11", id_valid, 1'b0);
      chk("R11", id_data, 16'h0000);
      rd_addr = 19'd0;
      // R12: idle junk leaves mode alone
      wr("R12", 19'h01234, 16'h0077, 1'b0);
      chk("R12", mode, 2'd1);
      // R8: single-write exit at arbitrary address
      wr("R8", 19'h3ABCD, 16'h99F0, 1'b0);
      chk("R8", mode, 2'd0);
      #1 chk("R11", id_valid, 1'b0);

      // R7 query, then R8 keyed exit
      key("R7");
      wr("R7", 19'h05555, 16'h0098, 1'b0);
      chk("R7", mode, 2'd2);
      key("R8");
      wr("R8", 19'h05555, 16'h00F0, 1'b0);
      chk("R8", mode, 2'd0);

      // R9: abort at erase stage five, from ID mode
      key("R9");
      wr("R9", 19'h05555, 16'h0090, 1'b0);
      key("R9");
      wr("R9", 19'h05555, 16'h0080, 1'b0);
      wr("R9", 19'h05555, 16'h00AA, 1'b0);
      wr("R9", 19'h02AAB, 16'h0055, 1'b0);
      chk("R9", mode, 2'd0);
      hold_a = op_addr;
      wr("R9", 19'h05555, 16'h0010, 1'b0);
      chk("R9", op_start, 1'b0);
      chk("R9", op_addr, hold_a);

      // R10: busy freezes a half-entered program sequence
      key("R10");
      wr("R10", 19'h05555, 16'h00F0, 1'b1);
      wr("R10", 19'h00000, 16'h1111, 1'b1);
      chk("R10", op_start, 1'b0);
      wr("R10", 19'h05555, 16'h00A0, 1'b0);
      wr("R10", 19'h12345, 16'h6789, 1'b1);
      chk("R10", op_start, 1'b0);
      wr("R10", 19'h12346, 16'h678A, 1'b0);
      chk("R10", op_start, 1'b1);
      chk("R10", op_addr, 19'h12346);

      for (int i = 0; i < 500; i++) rand_seq();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule